// File: doc/BRIEF.md
# Video Sync Timing Decoder

This block runs on the pixel clock and turns a raw pair of horizontal and vertical sync signals into per-pixel information: an X coordinate, a Y coordinate, a linear pixel index and a flag that marks the clock periods carrying active pixels. The image size, both back porches and the counter widths are compile-time parameters. Both sync inputs are active-high pulses. A line begins where the horizontal sync pulse ends, and a frame begins where the vertical sync pulse ends.

A lead parameter, `DATA_DELAY`, moves the valid flag and all coordinates earlier by a fixed number of clocks. Downstream logic that derives an address from the coordinates through a pipeline can then meet the pixel data without a FIFO. Timing terms used below: period `f` is the clock period in which `hsync_i` is first presented low after being high, so the rising edge that closes period `f` is the first to sample it low. Position `p` of a line is period `f + p`. Outputs seen in a period are the register values set by the rising edge that opened it.

Top module: `vtd_sync_decoder`

## Requirements
- R1: While reset is asserted and until the first line starts after it, `pix_valid` is 0 and `pix_x`, `pix_y` and `pix_index` are 0. The line count restarts from zero, which is the state after a vertical sync falling edge.
- R2: With `DATA_DELAY` = 0, `pix_valid` is high exactly at positions `H_BP+1` to `H_BP+WIDTH` of every active line. A longer low phase of `hsync_i` (a wider front porch) does not extend this window.
- R3: Horizontal sync falling edges after a vertical sync falling edge are numbered 1, 2, 3 and so on. Lines `V_BP+1` to `V_BP+HEIGHT` are active, and no other line raises `pix_valid`.
- R4: While `pix_valid` is high, `pix_x` runs from 0 to `WIDTH-1` and rises by one per clock. It is 0 on the first valid period of every line.
- R5: While `pix_valid` is high, `pix_y` equals the active line number minus `V_BP+1`, which is in the range 0 to `HEIGHT-1`.
- R6: While `pix_valid` is high, `pix_index` equals `pix_x + WIDTH*pix_y`. It rises by one per valid pixel and restarts at 0 after a vertical sync falling edge.
- R7: With `DATA_DELAY` = N (N < `H_BP`), the valid window and every coordinate are the `DATA_DELAY` = 0 ones moved N clocks earlier, so the window covers positions `H_BP+1-N` to `H_BP+WIDTH-N`.
- R8: While `pix_valid` is low, `pix_x`, `pix_y` and `pix_index` hold their last values.
- R9: A vertical sync falling edge, even in mid-frame, forces `pix_valid` low in the next period and restarts the line numbering. The next active line then reports `pix_y` = 0 and `pix_index` = 0.
- R10: A horizontal sync falling edge that is sampled on the same clock edge as a vertical sync falling edge does not count as a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_i | input | 1 | Horizontal sync, active-high pulse |
| vsync_i | input | 1 | Vertical sync, active-high pulse |
| pix_x | output | clog2(WIDTH) | Column of the current pixel |
| pix_y | output | clog2(HEIGHT) | Row of the current pixel |
| pix_index | output | clog2(WIDTH*HEIGHT) | Linear pixel number within the frame |
| pix_valid | output | 1 | High in periods that carry an active pixel |

## Verification
A stale or mis-set horizontal position shows up at the first valid period of the next line: the window edges move or `pix_x` does not start at 0, at most one line later. A wrong line count shows up as active rows being skipped or repeated, or as `pix_y` being out of step. It is visible at the first active line after the fault and is cleared at the next vertical sync falling edge. A pixel counter that drifts from the coordinates breaks the `pix_x + WIDTH*pix_y` relation on the very next valid pixel. The bench therefore compares every output on every clock for three lead values, against edge timestamps kept in the bench.

// File: rtl/vtd_pkg.sv
package vtd_pkg;

  typedef struct packed {
    logic line_start;   // hsync falling edge seen at this clock edge
    logic frame_start;  // vsync falling edge seen at this clock edge
  } vtd_evt_t;

  // width of a counter that holds values 0..n-1, at least one bit
  function automatic int cbits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/vtd_rst_sync.sv
module vtd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/vtd_fall_det.sv
module vtd_fall_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] sig_q;

  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q[gi] <= 1'b0;
      else        sig_q[gi] <= sig_i[gi];
    end
    assign fall_o[gi] = sig_q[gi] & ~sig_i[gi];
  end
endmodule

// File: rtl/vtd_win_count.sv
// Saturating position counter with a window decode on its next value.
module vtd_win_count #(
  parameter int CW          = 6,
  parameter int LO          = 5,
  parameter int SPAN        = 8,
  parameter int OW          = 3,
  parameter int RESTART_VAL = 1,
  parameter bit RST_TO_MAX  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          step_i,
  output logic          in_win_o,
  output logic [OW-1:0] offs_o
);
  localparam logic [CW-1:0] MAX_C     = '1;
  localparam logic [CW-1:0] RST_C     = RST_TO_MAX ? MAX_C : '0;
  localparam logic [CW-1:0] RESTART_C = CW'(RESTART_VAL);
  localparam logic [CW-1:0] LO_C      = CW'(LO);
  localparam logic [CW-1:0] HI_C      = CW'(LO + SPAN - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart_i)                      cnt_d = RESTART_C;
    else if (step_i && cnt_q != MAX_C)  cnt_d = cnt_q + CW'(1);
    else                                cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_C;
    else        cnt_q <= cnt_d;
  end

  assign in_win_o = (cnt_d >= LO_C) && (cnt_d <= HI_C);
  assign offs_o   = OW'(cnt_d - LO_C);
endmodule

// File: rtl/vtd_sync_decoder.sv
module vtd_sync_decoder
  import vtd_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int HEIGHT      = 4,
  parameter int H_BP        = 4,
  parameter int V_BP        = 2,
  parameter int WIDTH_BITS  = 6,
  parameter int HEIGHT_BITS = 4,
  parameter int DATA_DELAY  = 0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              hsync_i,
  input  logic                              vsync_i,
  output logic [cbits(WIDTH)-1:0]           pix_x,
  output logic [cbits(HEIGHT)-1:0]          pix_y,
  output logic [cbits(WIDTH*HEIGHT)-1:0]    pix_index,
  output logic                              pix_valid
);
  localparam int X_W  = cbits(WIDTH);
  localparam int Y_W  = cbits(HEIGHT);
  localparam int P_W  = cbits(WIDTH * HEIGHT);
  localparam int H_LO = H_BP + 1 - DATA_DELAY;
  localparam int V_LO = V_BP + 1;
  localparam logic [X_W-1:0] X_LAST = X_W'(WIDTH - 1);
  localparam logic [Y_W-1:0] Y_LAST = Y_W'(HEIGHT - 1);

  logic           rst_sync_n;
  logic [1:0]     fall;
  vtd_evt_t       evt;
  logic           h_in, v_in, valid_d;
  logic [X_W-1:0] x_d;
  logic [Y_W-1:0] y_d;
  logic [P_W-1:0] pix_cnt_q, pix_cnt_d;

  vtd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  vtd_fall_det #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .sig_i({vsync_i, hsync_i}), .fall_o(fall)
  );

  assign evt.line_start  = fall[0];
  assign evt.frame_start = fall[1];

  // horizontal position: 1 in the period after the hsync falling edge
  vtd_win_count #(
    .CW(WIDTH_BITS), .LO(H_LO), .SPAN(WIDTH), .OW(X_W),
    .RESTART_VAL(1), .RST_TO_MAX(1'b1)
  ) u_hpos (
    .clk(clk), .rst_n(rst_sync_n), .restart_i(evt.line_start), .step_i(1'b1),
    .in_win_o(h_in), .offs_o(x_d)
  );

  // line number: hsync falling edges since the last vsync falling edge
  vtd_win_count #(
    .CW(HEIGHT_BITS), .LO(V_LO), .SPAN(HEIGHT), .OW(Y_W),
    .RESTART_VAL(0), .RST_TO_MAX(1'b0)
  ) u_line (
    .clk(clk), .rst_n(rst_sync_n), .restart_i(evt.frame_start),
    .step_i(evt.line_start), .in_win_o(v_in), .offs_o(y_d)
  );

  always_comb begin
    valid_d = h_in & v_in;
    if (evt.frame_start) pix_cnt_d = '0;
    else if (valid_d)    pix_cnt_d = pix_cnt_q + P_W'(1);
    else                 pix_cnt_d = pix_cnt_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pix_cnt_q <= '0;
      pix_valid <= 1'b0;
      pix_x     <= '0;
      pix_y     <= '0;
      pix_index <= '0;
    end else begin
      pix_cnt_q <= pix_cnt_d;
      pix_valid <= valid_d;
      if (valid_d) begin
        pix_x     <= x_d;
        pix_y     <= y_d;
        pix_index <= pix_cnt_q;
      end
    end
  end

  // R4
  x_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pix_valid |-> pix_x <= X_LAST);

  // R5
  y_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pix_valid |-> pix_y <= Y_LAST);

  // R4
  line_start_x_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pix_valid) |-> pix_x == '0);

  // R4
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pix_valid && $past(pix_valid)) |-> pix_x == $past(pix_x) + X_W'(1));

  // R6
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pix_valid && $past(pix_valid)) |-> pix_index == $past(pix_index) + P_W'(1));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pix_valid |-> ($stable(pix_x) && $stable(pix_y) && $stable(pix_index)));

  // R9
  frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    evt.frame_start |=> !pix_valid);
endmodule

// File: tb/tb_vtd_sync_decoder.sv
module tb_vtd_sync_decoder;
  localparam int W = 8, H = 4, HBP = 4, VBP = 2;
  localparam int XW = $clog2(W), YW = $clog2(H), PW = $clog2(W * H);
  localparam int NI = 3;
  localparam int DLY [NI] = '{0, 1, 3};

  logic clk = 1'b0;
  logic rst_n, hsync, vsync;
  logic [XW-1:0] ox [NI];
  logic [YW-1:0] oy [NI];
  logic [PW-1:0] op [NI];
  logic          ov [NI];

  always #5 clk = ~clk;

  for (genvar gi = 0; gi < NI; gi++) begin : g_inst
    vtd_sync_decoder #(
      .WIDTH(W), .HEIGHT(H), .H_BP(HBP), .V_BP(VBP),
      .WIDTH_BITS(6), .HEIGHT_BITS(4), .DATA_DELAY(DLY[gi])
    ) dut (
      .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
      .pix_x(ox[gi]), .pix_y(oy[gi]), .pix_index(op[gi]), .pix_valid(ov[gi])
    );
  end

  int nchk = 0, nerr = 0;
  int cyc = 0, last_hf = 0, lines = 0;
  bit have_hf = 0, prev_hs = 0, prev_vs = 0;
  int e_v [NI], e_x [NI], e_y [NI], e_p [NI];
  string ph = "";

  task automatic cmp(input int got, input int exp, input string req, input string what, input int i);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s [%s] D=%0d %s: actual=%0d expected=%0d (cycle %0d)",
               req, ph, DLY[i], what, got, exp, cyc);
    end
  endtask

  task automatic check_all();
    for (int i = 0; i < NI; i++) begin
      string rq;
      if (DLY[i] != 0) rq = "R7";
      else if (lines < VBP + 1 || lines > VBP + H) rq = "R3";
      else rq = "R2";
      cmp(int'(ov[i]), e_v[i], rq, "valid", i);
      cmp(int'(ox[i]), e_x[i], e_v[i] != 0 ? "R4" : "R8", "x", i);
      cmp(int'(oy[i]), e_y[i], e_v[i] != 0 ? "R5" : "R8", "y", i);
      cmp(int'(op[i]), e_p[i], e_v[i] != 0 ? "R6" : "R8", "index", i);
    end
  endtask

  // expectation for the period after the coming rising edge
  task automatic predict();
    for (int i = 0; i < NI; i++) begin
      int lo = HBP + 1 - DLY[i];
      int pos = cyc - last_hf + 1;
      bit v = have_hf && pos >= lo && pos <= lo + W - 1 &&
              lines >= VBP + 1 && lines <= VBP + H;
      e_v[i] = v;
      if (v) begin
        e_x[i] = pos - lo;
        e_y[i] = lines - VBP - 1;
        e_p[i] = e_x[i] + W * e_y[i];
      end
    end
  endtask

  task automatic step(input bit hs, input bit vs);
    @(negedge clk);
    check_all();
    hsync = hs;
    vsync = vs;
    cyc++;
    if (prev_hs && !hs) begin
      last_hf = cyc;
      have_hf = 1;
    end
    if (prev_vs && !vs) lines = 0;            // R10: coincident hsync edge not counted
    else if (prev_hs && !hs) lines++;
    prev_hs = hs;
    prev_vs = vs;
    predict();
  endtask

  task automatic line(input int hi, input int lo, input bit vs_a, input bit vs_b, input int sw);
    for (int k = 0; k < hi + lo; k++) step(k < hi, (k < sw) ? vs_a : vs_b);
  endtask

  task automatic frame(input bit coinc, input int lo_len);
    line(3, lo_len, 1, 1, 0);
    line(3, lo_len, 1, 0, coinc ? 3 : 1);
    for (int l = 0; l < 9; l++) line(3, lo_len, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    hsync = 1'b0;
    vsync = 1'b0;
    #1;
    for (int i = 0; i < NI; i++) begin
      cmp(int'(ov[i]), 0, "R1", "valid in reset", i);
      cmp(int'(ox[i]) + int'(oy[i]) + int'(op[i]), 0, "R1", "coords in reset", i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    prev_hs = 0; prev_vs = 0; have_hf = 0; lines = 0;
    for (int i = 0; i < NI; i++) begin
      e_v[i] = 0; e_x[i] = 0; e_y[i] = 0; e_p[i] = 0;
    end
    ph = "R1 after reset";
    repeat (4) step(0, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    hsync = 1'b0;
    vsync = 1'b0;
    do_reset();
    ph = "R2 R3 R4 R5 R6 R7 baseline";
    frame(0, 16);
    frame(0, 16);
    ph = "R10 coincident edges";
    frame(1, 16);
    ph = "R2 long front porch";
    frame(0, 30);
    ph = "R9 mid-frame resync";
    line(3, 16, 1, 1, 0);
    line(3, 16, 1, 0, 1);
    for (int l = 0; l < 4; l++) line(3, 16, 0, 0, 0);
    line(3, 16, 1, 1, 0);
    line(3, 16, 1, 0, 1);
    for (int l = 0; l < 9; l++) line(3, 16, 0, 0, 0);
    ph = "R1 reset mid-line";
    line(3, 9, 0, 0, 0);
    do_reset();
    ph = "R9 recovery after reset";
    frame(0, 16);
    step(0, 0);
    summary();
    $finish;
  end
endmodule